// File: doc/BRIEF.md
# I2C EEPROM Sequential Read Master

This block is a bus master that pulls a fixed-length run of bytes out of a serial EEPROM in one combined transaction. A single-cycle start pulse launches it. The block sends a START and the device address with the write bit, then the configured word address. It switches direction with a repeated START, not a STOP, and resends the device address with the read bit. It then clocks in the configured number of data bytes. Each received byte appears on a parallel output together with a one-cycle strobe.

The master drives SCL directly. It handles SDA as an open-drain line: one output asks to pull the line low, and one input returns the resolved line level. Each bit period is split into four equal quarters, and a runtime divider input sets their length. The master acknowledges every data byte except the final one. It releases SDA in the final acknowledge slot and then ends the transfer with a STOP. If the device fails to acknowledge any byte the master sends, the master stops at once and flags an error.

Top module: `i2c_seqrd`

## Requirements
- R1: After reset, and whenever no transaction is in progress, scl_o is 1, sda_oe_o is 0 and busy_o is 0.
- R2: A start_i pulse while idle produces a START (SDA falls while SCL is high), followed by the byte {DEV_ADDR, 0} (0xA0 for the default address), sent MSB first.
- R3: After that byte is acknowledged, the byte WORD_ADDR is sent MSB first, and the device acknowledge is sampled in the ninth clock.
- R4: After the word address is acknowledged, a repeated START follows with no STOP in between, then the byte {DEV_ADDR, 1} (0xA1 for the default address).
- R5: N_BYTES data bytes are then read MSB first. Each byte is presented on data_o with a one-cycle data_valid_o pulse, in the order the device sends them.
- R6: In the ninth clock of every data byte except the last, the master pulls SDA low (ACK).
- R7: In the ninth clock of the last data byte, SDA is left released (NACK). A STOP follows (SDA rises while SCL is high), then done_o pulses for one cycle with err_o at 0.
- R8: If the ninth clock of any of the three bytes the master sends samples SDA high, the master sends a STOP, pulses done_o, sets err_o to 1 and reads no data. err_o is cleared by the next accepted start_i.
- R9: During address, data and acknowledge bits, SDA changes only while SCL is low. A transaction therefore contains exactly the intended START, repeated START and STOP conditions.
- R10: Each quarter lasts clk_div_i+1 clock cycles, so every SCL high pulse within a transaction lasts 2*(clk_div_i+1) cycles.
- R11: start_i is ignored while busy_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to run a transaction |
| clk_div_i | input | DIV_W | Quarter-bit length minus one, in clock cycles |
| scl_o | output | 1 | Serial clock line |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| sda_i | input | 1 | Resolved SDA level |
| data_o | output | 8 | Last received data byte |
| data_valid_o | output | 1 | One-cycle strobe for data_o |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle pulse at the end of a transaction |
| err_o | output | 1 | Last transaction aborted on a missing device acknowledge |

## Verification
The bench attaches a cycle-level EEPROM model that decodes START and STOP from the line itself. It logs every byte it receives and the master's acknowledge on every byte it returns. This detects a master that NACKs early or ACKs the last byte: the model would either lose data or keep pulling SDA low into the STOP. It also detects a master that uses STOP plus START instead of a repeated START, because the model counts the stop conditions. The bench sweeps the divider to catch quarter-counting errors in the SCL high time. It refuses the acknowledge at each of the three master-sent bytes in turn, where a faulty abort path would hang, miss the error flag, or go on to read data. A start pulse fired in the middle of a transfer would add a condition or a second done pulse if busy gating were missing.

// File: rtl/i2c_seqrd_pkg.sv
package i2c_seqrd_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_TX, ST_RX, ST_STOP} st_e;
  typedef enum logic [1:0] {PH_ADDR_W, PH_WORD, PH_ADDR_R, PH_READ} ph_e;
  typedef enum logic [1:0] {LN_IDLE, LN_START, LN_BIT, LN_STOP} ln_e;
endpackage

// File: rtl/i2c_seqrd_qtick.sv
module i2c_seqrd_qtick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic [1:0]       q_o
);
  logic [DIV_W-1:0] cnt;

  assign tick_o = run_i && (cnt >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt <= '0;
      q_o <= '0;
    end else if (!run_i) begin
      cnt <= '0;
      q_o <= '0;
    end else if (tick_o) begin
      cnt <= '0;
      q_o <= q_o + 2'd1;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  AST_QUARTER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && !$past(tick_o)) |-> (q_o == $past(q_o))); // R10
endmodule

// File: rtl/i2c_seqrd_line.sv
module i2c_seqrd_line
  import i2c_seqrd_pkg::*;
(
  input  ln_e        kind_i,
  input  logic [1:0] q_i,
  input  logic       bit_low_i,
  output logic       scl_o,
  output logic       sda_oe_o
);
  // quarters: 0 low, 1-2 high, 3 low; conditions move SDA in quarter 2
  always_comb begin
    unique case (kind_i)
      LN_START: begin
        scl_o    = (q_i == 2'd1) || (q_i == 2'd2);
        sda_oe_o = q_i[1];
      end
      LN_BIT: begin
        scl_o    = (q_i == 2'd1) || (q_i == 2'd2);
        sda_oe_o = bit_low_i;
      end
      LN_STOP: begin
        scl_o    = (q_i != 2'd0);
        sda_oe_o = !q_i[1];
      end
      default: begin
        scl_o    = 1'b1;
        sda_oe_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/i2c_seqrd.sv
module i2c_seqrd
  import i2c_seqrd_pkg::*;
#(
  parameter int         N_BYTES   = 128,
  parameter int         DIV_W     = 8,
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter logic [7:0] WORD_ADDR = 8'h00
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DIV_W-1:0] clk_div_i,
  output logic             scl_o,
  output logic             sda_oe_o,
  input  logic             sda_i,
  output logic [7:0]       data_o,
  output logic             data_valid_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  localparam int CNT_W = $clog2(N_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_BYTES - 1);

  st_e              state;
  ph_e              phase;
  logic [3:0]       bit_cnt;
  logic [7:0]       tx_sr, rx_sr;
  logic [CNT_W-1:0] byte_cnt;
  logic             nack_q, tick, sym_end, smp, last_byte, bit_low;
  logic [1:0]       q;
  ln_e              kind;

  assign busy_o    = (state != ST_IDLE);
  assign sym_end   = tick && (q == 2'd3);
  assign smp       = tick && (q == 2'd1);
  assign last_byte = (byte_cnt == LAST);

  i2c_seqrd_qtick #(.DIV_W(DIV_W)) qtick_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_o),
    .div_i  (clk_div_i),
    .tick_o (tick),
    .q_o    (q)
  );

  always_comb begin
    bit_low = 1'b0;
    kind    = LN_IDLE;
    unique case (state)
      ST_START: kind = LN_START;
      ST_TX: begin
        kind    = LN_BIT;
        bit_low = (bit_cnt != 4'd8) && !tx_sr[7];
      end
      ST_RX: begin
        kind    = LN_BIT;
        bit_low = (bit_cnt == 4'd8) && !last_byte;
      end
      ST_STOP: kind = LN_STOP;
      default: kind = LN_IDLE;
    endcase
  end

  i2c_seqrd_line line_i (
    .kind_i    (kind),
    .q_i       (q),
    .bit_low_i (bit_low),
    .scl_o     (scl_o),
    .sda_oe_o  (sda_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state        <= ST_IDLE;
      phase        <= PH_ADDR_W;
      bit_cnt      <= '0;
      tx_sr        <= '0;
      rx_sr        <= '0;
      byte_cnt     <= '0;
      nack_q       <= 1'b0;
      data_o       <= '0;
      data_valid_o <= 1'b0;
      done_o       <= 1'b0;
      err_o        <= 1'b0;
    end else begin
      data_valid_o <= 1'b0;
      done_o       <= 1'b0;
      unique case (state)
        ST_IDLE: if (start_i) begin
          state    <= ST_START;
          phase    <= PH_ADDR_W;
          byte_cnt <= '0;
          nack_q   <= 1'b0;
          err_o    <= 1'b0;
        end
        ST_START: if (sym_end) begin
          state   <= ST_TX;
          bit_cnt <= '0;
          tx_sr   <= {DEV_ADDR, phase == PH_ADDR_R};
        end
        ST_TX: begin
          if (smp && bit_cnt == 4'd8) nack_q <= sda_i;
          if (sym_end) begin
            if (bit_cnt != 4'd8) begin
              tx_sr   <= {tx_sr[6:0], 1'b0};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (nack_q) begin
              state <= ST_STOP;
            end else begin
              bit_cnt <= '0;
              unique case (phase)
                PH_ADDR_W: begin
                  phase <= PH_WORD;
                  tx_sr <= WORD_ADDR;
                end
                PH_WORD: begin
                  phase <= PH_ADDR_R;
                  state <= ST_START;
                end
                PH_ADDR_R: begin
                  phase <= PH_READ;
                  state <= ST_RX;
                end
                default: state <= ST_STOP;
              endcase
            end
          end
        end
        ST_RX: begin
          if (smp && bit_cnt != 4'd8) begin
            rx_sr <= {rx_sr[6:0], sda_i};
            if (bit_cnt == 4'd7) begin
              data_o       <= {rx_sr[6:0], sda_i};
              data_valid_o <= 1'b1;
            end
          end
          if (sym_end) begin
            if (bit_cnt != 4'd8) begin
              bit_cnt <= bit_cnt + 4'd1;
            end else if (last_byte) begin
              state <= ST_STOP;
            end else begin
              byte_cnt <= byte_cnt + CNT_W'(1);
              bit_cnt  <= '0;
            end
          end
        end
        ST_STOP: if (sym_end) begin
          state  <= ST_IDLE;
          done_o <= 1'b1;
          err_o  <= nack_q;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_LINES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> (scl_o && !sda_oe_o)); // R1
  AST_SDA_HOLD_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state == ST_TX || state == ST_RX) && state == $past(state) && scl_o && $past(scl_o))
      |-> $stable(sda_oe_o)); // R9
  AST_LAST_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_RX && bit_cnt == 4'd8 && last_byte) |-> !sda_oe_o); // R7
  AST_VALID_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> (state == ST_RX && phase == PH_READ)); // R5
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R7
  AST_START_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy_o) && !$past(done_o) && $past(state) != ST_STOP) |-> busy_o); // R11
endmodule

// File: tb/i2c_seqrd_tb.sv
module i2c_seqrd_tb_top;
  localparam int         NB   = 4;
  localparam int         DW   = 4;
  localparam logic [6:0] DEV  = 7'h50;
  localparam logic [7:0] WORD = 8'h3C;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [DW-1:0] clk_div_i = '0;
  logic          scl_o, sda_oe_o, sda_line, data_valid_o, busy_o, done_o, err_o;
  logic [7:0]    data_o;
  logic          sl_low = 1'b0;

  int checks = 0, errors = 0;

  always #4 clk_i = ~clk_i;

  assign sda_line = !(sda_oe_o || sl_low);

  i2c_seqrd #(.N_BYTES(NB), .DIV_W(DW), .DEV_ADDR(DEV), .WORD_ADDR(WORD)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .clk_div_i(clk_div_i),
    .scl_o(scl_o), .sda_oe_o(sda_oe_o), .sda_i(sda_line), .data_o(data_o),
    .data_valid_o(data_valid_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  function automatic logic [7:0] mem(input logic [7:0] a);
    return a * 8'd37 + 8'd5;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // EEPROM model state
  int         starts, stops, wr_n, rd_n, bitn, ridx, w_n, w_bad, hi_cnt, got, done_n;
  int         nack_at, cur_div;
  logic [7:0] wr_log [0:7];
  logic       mack [0:15];
  logic [7:0] sh, ptr, cur;
  logic       rd, quiet, in_txn, pend_rd, p_scl, p_sda, nak;

  initial begin
    starts = 0; stops = 0; wr_n = 0; rd_n = 0; bitn = 0; ridx = 0; w_n = 0; w_bad = 0;
    hi_cnt = 0; got = 0; done_n = 0; nack_at = -1; cur_div = 0;
    sh = '0; ptr = '0; cur = '0; rd = 0; quiet = 0; in_txn = 0; pend_rd = 0;
    p_scl = 1; p_sda = 1; nak = 0;
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (p_scl && !scl_o && in_txn) begin
        w_n++;
        if (hi_cnt != 2 * (cur_div + 1)) w_bad++;
      end
      if (scl_o) hi_cnt = p_scl ? hi_cnt + 1 : 1;
      if (p_scl && scl_o && p_sda && !sda_line) begin
        starts++; in_txn = 1; bitn = 0; rd = 0; quiet = 0; sl_low = 0; pend_rd = 0;
      end else if (p_scl && scl_o && !p_sda && sda_line) begin
        stops++; in_txn = 0; bitn = 0; rd = 0; quiet = 0; sl_low = 0; pend_rd = 0;
      end else if (!p_scl && scl_o) begin
        if (!quiet) begin
          if (rd) begin
            if (bitn == 8) begin mack[rd_n] = sda_line; rd_n++; end
            bitn++;
          end else begin
            if (bitn < 8) sh = {sh[6:0], sda_line};
            bitn++;
          end
        end
      end else if (p_scl && !scl_o && !quiet) begin
        if (rd) begin
          if (bitn >= 1 && bitn <= 7) sl_low = !cur[7-bitn];
          else if (bitn == 8) sl_low = 0;
          else if (bitn == 9) begin
            if (!mack[rd_n-1]) begin
              ridx++; cur = mem(ptr + 8'(ridx)); bitn = 0; sl_low = !cur[7];
            end else begin
              quiet = 1; sl_low = 0;
            end
          end
        end else if (bitn == 8) begin
          wr_log[wr_n] = sh;
          nak = (wr_n == nack_at);
          sl_low = !nak;
          pend_rd = sh[0] && !nak;
          if (wr_n == 1) ptr = sh;
          wr_n++;
        end else if (bitn == 9) begin
          sl_low = 0; bitn = 0;
          if (pend_rd) begin
            rd = 1; ridx = 0; cur = mem(ptr); sl_low = !cur[7]; pend_rd = 0;
          end
        end
      end
      p_scl = scl_o; p_sda = sda_line;
      if (data_valid_o) begin
        chk(data_o == mem(WORD + 8'(got)), "R5 data byte", data_o, mem(WORD + 8'(got)));
        got++;
      end
      if (done_o) done_n++;
    end
  end

  task automatic run_txn(input int div, input int nak_idx, input bit inject);
    bit fin = 0;
    int exp_wr, exp_starts;
    @(negedge clk_i);
    starts = 0; stops = 0; wr_n = 0; rd_n = 0; w_n = 0; w_bad = 0; got = 0; done_n = 0;
    nack_at = nak_idx; cur_div = div;
    clk_div_i = DW'(div);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int c = 0; c < 20000 && !fin; c++) begin
      @(negedge clk_i);
      if (inject && c == 60) begin
        chk(busy_o, "R11 busy mid-transfer", busy_o, 1);
        start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
      end
      if (done_n > 0) fin = 1;
    end
    chk(fin, "watchdog done_o", fin, 1);
    repeat (4 * (div + 1)) @(negedge clk_i);
    exp_wr     = (nak_idx < 0) ? 3 : nak_idx + 1;
    exp_starts = (nak_idx < 0 || nak_idx == 2) ? 2 : 1;
    chk(err_o == (nak_idx >= 0), "R8 err_o", err_o, nak_idx >= 0);
    chk(done_n == 1, "R11 one done pulse", done_n, 1);
    chk(starts == exp_starts, "R4 R9 start count", starts, exp_starts);
    chk(stops == 1, "R7 R9 stop count", stops, 1);
    chk(wr_n == exp_wr, "R8 bytes sent", wr_n, exp_wr);
    chk(wr_log[0] == {DEV, 1'b0}, "R2 write address byte", wr_log[0], {DEV, 1'b0});
    if (exp_wr > 1) chk(wr_log[1] == WORD, "R3 word address", wr_log[1], WORD);
    if (exp_wr > 2) chk(wr_log[2] == {DEV, 1'b1}, "R4 read address byte", wr_log[2], {DEV, 1'b1});
    if (nak_idx < 0) begin
      chk(got == NB, "R5 byte count", got, NB);
      chk(rd_n == NB, "R6 ack slots", rd_n, NB);
      for (int i = 0; i < NB - 1; i++) chk(mack[i] == 1'b0, "R6 ACK not last", mack[i], 0);
      chk(mack[NB-1] == 1'b1, "R7 NACK last", mack[NB-1], 1);
    end else begin
      chk(got == 0, "R8 no data on abort", got, 0);
    end
    chk(w_n > 0 && w_bad == 0, "R10 SCL high width", w_bad, 0);
    chk(scl_o && !sda_oe_o && !busy_o, "R1 idle lines after done", {scl_o, sda_oe_o, busy_o}, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(scl_o && !sda_oe_o && !busy_o && !done_o && !err_o && !data_valid_o,
        "R1 reset state", {scl_o, sda_oe_o, busy_o, done_o, err_o}, 16);
    for (int d = 0; d < 4; d++) run_txn(d, -1, 1'b0);
    for (int k = 0; k < 3; k++) run_txn(1, k, 1'b0);
    run_txn(2, -1, 1'b1);
    run_txn(0, -1, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule